// File: doc/BRIEF.md
# Dual-Channel Pixel Interleaver with Black Clamp

The block receives digitized samples from two sensor readout channels. One channel delivers the odd-numbered columns of a line and the other the even-numbered columns, with the two sampled half a pixel period apart. The block merges them into one raster-ordered pixel stream that can run at twice the rate of either channel. At the start of each line it discards a fixed number of dummy samples per channel. It then uses the optically shielded samples that follow to estimate the line's black level, and subtracts that level from every active pixel before output.

Each output pixel has start-of-line, end-of-line and start-of-frame markers, and a tag for pixels from the shielded lines at the bottom of the frame. A per-channel error pulse reports any line whose sample count on that channel was wrong.

Usage rules:
- Each channel strobes at most once every two clock cycles.
- `line_start_i` pulses once before each line.
- `frame_start_i` pulses together with `line_start_i` on the first line of a frame.
- At least four idle cycles separate the last sample of a line from the next `line_start_i`.

Top module: `dual_pix_interleaver`

## Requirements
- R1: On each channel, the first DUMMY_N samples after `line_start_i` never reach the output.
- R2: Per line, the black level is floor(S / (2*DARK_N)), where S is the sum of the 2*DARK_N samples that follow the dummies on the two channels. Each active pixel is output as its sample minus that line's black level.
- R3: When an active sample is below the black level, the output value is 0.
- R4: Output pixels leave in column order 1 to 2*ACT_N, one per cycle at most. Odd columns come from the odd channel and even columns from the even channel, alternating and starting with the odd channel.
- R5: `pix_sol_o` is high only on column 1, and `pix_eol_o` is high only on column 2*ACT_N.
- R6: `pix_sof_o` is high only on column 1 of line index 0. Line index 0 is the line begun by `frame_start_i`.
- R7: `pix_dark_line_o` is high on every pixel of lines with index LINES_ACT or above. The line index saturates at LINES_ACT+LINES_DARK-1.
- R8: `cnt_err_o` bit 0 (odd channel) or bit 1 (even channel) pulses for one cycle, in the cycle after `line_start_i`, when that channel delivered a count other than DUMMY_N+DARK_N+ACT_N in the previous line. No pulse occurs for the first line after reset.
- R9: Samples beyond DUMMY_N+DARK_N+ACT_N on a channel within one line are dropped.
- R10: `line_start_i` discards any pixels of the previous line that have not yet been output. The new line is unaffected by them.
- R11: During and right after reset, `pix_vld_o` and `cnt_err_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| frame_start_i | input | 1 | First line of a frame follows (with line_start_i) |
| line_start_i | input | 1 | A new line follows |
| odd_vld_i | input | 1 | Odd-column channel sample strobe |
| odd_data_i | input | DW | Odd-column channel sample |
| even_vld_i | input | 1 | Even-column channel sample strobe |
| even_data_i | input | DW | Even-column channel sample |
| pix_vld_o | output | 1 | Output pixel valid |
| pix_data_o | output | DW | Black-corrected pixel value |
| pix_sol_o | output | 1 | First active column of the line |
| pix_eol_o | output | 1 | Last active column of the line |
| pix_sof_o | output | 1 | First pixel of the frame |
| pix_dark_line_o | output | 1 | Pixel belongs to a shielded bottom line |
| cnt_err_o | output | 2 | Per-channel sample-count error pulse |

## Verification
A wrong per-channel sample counter shows up in two ways. A dummy or shielded sample leaks into the pixel stream, or the line's pixel count comes out short or long, and either is visible on the first pixel of the affected line. A wrong black accumulator shifts every pixel of that line by a constant, and the saturating test line shows it as nonzero values where zeros are due. A wrong turn bit or a stale skid entry swaps or repeats neighbouring columns at once. A stale line index moves the frame and dark-line markers by whole lines. A wrong count check shows up as an error pulse, or a missing one, one cycle after the next line start.

// File: rtl/pxi_pkg.sv
package pxi_pkg;
  typedef enum logic [1:0] {
    SEG_DUMMY,
    SEG_DARK,
    SEG_ACTIVE,
    SEG_EXCESS
  } seg_e;
endpackage

// File: rtl/pxi_chan_front.sv
module pxi_chan_front
  import pxi_pkg::*;
#(
  parameter int unsigned DUMMY_N = 12,
  parameter int unsigned DARK_N  = 12,
  parameter int unsigned ACT_N   = 500
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_start_i,
  input  logic smp_vld_i,
  output logic dark_vld_o,
  output logic act_vld_o,
  output logic cnt_err_o
);
  localparam int unsigned TOTAL_N = DUMMY_N + DARK_N + ACT_N;
  localparam int unsigned CW      = $clog2(TOTAL_N + 2);

  logic [CW-1:0] cnt_q, cnt_eff;
  logic          seen_q, err_q;
  seg_e          seg;

  // a strobe in the line_start cycle is sample 0 of the new line
  assign cnt_eff = line_start_i ? '0 : cnt_q;

  always_comb begin
    if (cnt_eff < CW'(DUMMY_N))               seg = SEG_DUMMY;
    else if (cnt_eff < CW'(DUMMY_N + DARK_N)) seg = SEG_DARK;
    else if (cnt_eff < CW'(TOTAL_N))          seg = SEG_ACTIVE;
    else                                      seg = SEG_EXCESS;
  end

  assign dark_vld_o = smp_vld_i && (seg == SEG_DARK);
  assign act_vld_o  = smp_vld_i && (seg == SEG_ACTIVE);
  assign cnt_err_o  = err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      err_q <= line_start_i && seen_q && (cnt_q != CW'(TOTAL_N));
      if (line_start_i) seen_q <= 1'b1;
      // saturate one past the total so long lines stay detectable
      if (smp_vld_i && (cnt_eff != CW'(TOTAL_N + 1))) cnt_q <= cnt_eff + CW'(1);
      else                                            cnt_q <= cnt_eff;
    end
  end

  AST_ERR_AFTER_LINE_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_err_o |-> $past(line_start_i)); // R8
endmodule

// File: rtl/pxi_skid2.sv
module pxi_skid2 #(
  parameter int unsigned DW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [DW-1:0] data_i,
  input  logic          pop_i,
  output logic [DW-1:0] data_o,
  output logic          nempty_o
);
  logic [DW-1:0] mem_q [2];
  logic          wp_q, rp_q;
  logic [1:0]    cnt_q;
  logic          wsel;

  assign wsel     = flush_i ? 1'b0 : wp_q;
  assign data_o   = mem_q[rp_q];
  assign nempty_o = (cnt_q != 2'd0);

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wsel] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= 1'b0;
      rp_q  <= 1'b0;
      cnt_q <= 2'd0;
    end else if (flush_i) begin
      wp_q  <= push_i;
      rp_q  <= 1'b0;
      cnt_q <= {1'b0, push_i};
    end else begin
      wp_q  <= wp_q ^ push_i;
      rp_q  <= rp_q ^ pop_i;
      cnt_q <= cnt_q + {1'b0, push_i} - {1'b0, pop_i};
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flush_i && push_i && !pop_i) |-> (cnt_q < 2'd2)); // R4
  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flush_i && pop_i) |-> (cnt_q != 2'd0)); // R4
endmodule

// File: rtl/pxi_black_est.sv
module pxi_black_est #(
  parameter int unsigned DW         = 12,
  parameter int unsigned DARK_TOTAL = 24
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                line_start_i,
  input  logic [1:0]          dark_vld_i,
  input  logic [1:0][DW-1:0]  dark_data_i,
  output logic [DW-1:0]       black_o,
  output logic                rdy_o
);
  localparam int unsigned NW = $clog2(DARK_TOTAL + 1);
  localparam int unsigned SW = DW + NW;

  logic [SW-1:0] sum_q, sum_nx;
  logic [NW-1:0] n_q, n_nx;
  logic          rdy_q, rdy_base, done_nx;
  logic [DW-1:0] black_q;

  always_comb begin
    sum_nx   = line_start_i ? '0 : sum_q;
    n_nx     = line_start_i ? '0 : n_q;
    rdy_base = line_start_i ? 1'b0 : rdy_q;
    for (int c = 0; c < 2; c++) begin
      if (dark_vld_i[c]) begin
        sum_nx = sum_nx + SW'(dark_data_i[c]);
        n_nx   = n_nx + NW'(1);
      end
    end
  end

  assign done_nx = (n_nx == NW'(DARK_TOTAL));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_q   <= '0;
      n_q     <= '0;
      rdy_q   <= 1'b0;
      black_q <= '0;
    end else begin
      sum_q <= sum_nx;
      n_q   <= n_nx;
      rdy_q <= rdy_base | done_nx;
      // constant divisor: exact floor average
      if (!rdy_base && done_nx) black_q <= DW'(sum_nx / SW'(DARK_TOTAL));
    end
  end

  assign black_o = black_q;
  assign rdy_o   = rdy_q;

  AST_RDY_AFTER_DARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rdy_o) |-> $past(|dark_vld_i)); // R2
endmodule

// File: rtl/pxi_merge.sv
module pxi_merge #(
  parameter int unsigned DW         = 12,
  parameter int unsigned ACT_N      = 500,
  parameter int unsigned LINES_ACT  = 510,
  parameter int unsigned LINES_DARK = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               frame_start_i,
  input  logic               line_start_i,
  input  logic [DW-1:0]      black_i,
  input  logic               black_rdy_i,
  input  logic [1:0]         nempty_i,
  input  logic [1:0][DW-1:0] head_i,
  output logic [1:0]         pop_o,
  output logic               pix_vld_o,
  output logic [DW-1:0]      pix_data_o,
  output logic               pix_sol_o,
  output logic               pix_eol_o,
  output logic               pix_sof_o,
  output logic               pix_dark_line_o
);
  localparam int unsigned COLS    = 2 * ACT_N;
  localparam int unsigned CLW     = $clog2(COLS + 1);
  localparam int unsigned LINES_T = LINES_ACT + LINES_DARK;
  localparam int unsigned LW      = $clog2(LINES_T + 1);

  logic           turn_q;
  logic [CLW-1:0] col_q;
  logic [LW-1:0]  line_q;
  logic           pop_any;
  logic [DW-1:0]  sel_data, clamped;
  logic [DW:0]    diff;

  assign sel_data = head_i[turn_q];
  assign pop_any  = !line_start_i && black_rdy_i && nempty_i[turn_q] && (col_q < CLW'(COLS));
  assign pop_o[0] = pop_any && !turn_q;
  assign pop_o[1] = pop_any && turn_q;

  assign diff    = {1'b0, sel_data} - {1'b0, black_i};
  assign clamped = diff[DW] ? '0 : diff[DW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      turn_q <= 1'b0;
      col_q  <= '0;
      line_q <= '0;
    end else begin
      if (frame_start_i)                                    line_q <= '0;
      else if (line_start_i && (line_q < LW'(LINES_T - 1))) line_q <= line_q + LW'(1);
      if (line_start_i) begin
        turn_q <= 1'b0;
        col_q  <= '0;
      end else if (pop_any) begin
        turn_q <= ~turn_q;
        col_q  <= col_q + CLW'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pix_vld_o       <= 1'b0;
      pix_data_o      <= '0;
      pix_sol_o       <= 1'b0;
      pix_eol_o       <= 1'b0;
      pix_sof_o       <= 1'b0;
      pix_dark_line_o <= 1'b0;
    end else begin
      pix_vld_o       <= pop_any;
      pix_data_o      <= clamped;
      pix_sol_o       <= pop_any && (col_q == '0);
      pix_eol_o       <= pop_any && (col_q == CLW'(COLS - 1));
      pix_sof_o       <= pop_any && (col_q == '0) && (line_q == '0);
      pix_dark_line_o <= pop_any && (line_q >= LW'(LINES_ACT));
    end
  end

  AST_SOF_WITH_SOL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_sof_o |-> (pix_sol_o && pix_vld_o)); // R6
  AST_CLAMP_NO_GAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_any |=> (pix_data_o <= $past(sel_data))); // R3
  AST_POP_NEEDS_BLACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_vld_o |-> $past(black_rdy_i)); // R2
endmodule

// File: rtl/dual_pix_interleaver.sv
module dual_pix_interleaver #(
  parameter int unsigned DW         = 12,
  parameter int unsigned DUMMY_N    = 12,
  parameter int unsigned DARK_N     = 12,
  parameter int unsigned ACT_N      = 500,
  parameter int unsigned LINES_ACT  = 510,
  parameter int unsigned LINES_DARK = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          frame_start_i,
  input  logic          line_start_i,
  input  logic          odd_vld_i,
  input  logic [DW-1:0] odd_data_i,
  input  logic          even_vld_i,
  input  logic [DW-1:0] even_data_i,
  output logic          pix_vld_o,
  output logic [DW-1:0] pix_data_o,
  output logic          pix_sol_o,
  output logic          pix_eol_o,
  output logic          pix_sof_o,
  output logic          pix_dark_line_o,
  output logic [1:0]    cnt_err_o
);
  localparam int unsigned DARK_TOTAL = 2 * DARK_N;

  logic [1:0]         ch_vld, dark_vld, act_vld, nempty, pop;
  logic [1:0][DW-1:0] ch_data, head;
  logic [DW-1:0]      black;
  logic               black_rdy;

  assign ch_vld  = {even_vld_i, odd_vld_i};
  assign ch_data = {even_data_i, odd_data_i};

  for (genvar c = 0; c < 2; c++) begin : g_ch
    pxi_chan_front #(
      .DUMMY_N(DUMMY_N), .DARK_N(DARK_N), .ACT_N(ACT_N)
    ) front_i (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .line_start_i(line_start_i),
      .smp_vld_i   (ch_vld[c]),
      .dark_vld_o  (dark_vld[c]),
      .act_vld_o   (act_vld[c]),
      .cnt_err_o   (cnt_err_o[c])
    );

    pxi_skid2 #(.DW(DW)) skid_i (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .flush_i (line_start_i),
      .push_i  (act_vld[c]),
      .data_i  (ch_data[c]),
      .pop_i   (pop[c]),
      .data_o  (head[c]),
      .nempty_o(nempty[c])
    );
  end

  pxi_black_est #(.DW(DW), .DARK_TOTAL(DARK_TOTAL)) black_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .line_start_i(line_start_i),
    .dark_vld_i  (dark_vld),
    .dark_data_i (ch_data),
    .black_o     (black),
    .rdy_o       (black_rdy)
  );

  pxi_merge #(
    .DW(DW), .ACT_N(ACT_N), .LINES_ACT(LINES_ACT), .LINES_DARK(LINES_DARK)
  ) merge_i (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .frame_start_i  (frame_start_i),
    .line_start_i   (line_start_i),
    .black_i        (black),
    .black_rdy_i    (black_rdy),
    .nempty_i       (nempty),
    .head_i         (head),
    .pop_o          (pop),
    .pix_vld_o      (pix_vld_o),
    .pix_data_o     (pix_data_o),
    .pix_sol_o      (pix_sol_o),
    .pix_eol_o      (pix_eol_o),
    .pix_sof_o      (pix_sof_o),
    .pix_dark_line_o(pix_dark_line_o)
  );

  AST_ERR_ONEHOT_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|cnt_err_o) |=> (cnt_err_o == 2'b00)); // R8
endmodule

// File: tb/dual_pix_interleaver_tb_top.sv
module dual_pix_interleaver_tb_top;
  localparam int DW    = 8;
  localparam int DUMMY = 2;
  localparam int DARK  = 2;
  localparam int ACT   = 3;
  localparam int LA    = 2;
  localparam int LD    = 1;
  localparam int TOT   = DUMMY + DARK + ACT;
  localparam int COLS  = 2 * ACT;

  // {odd dark base, even dark base, active base, active step}
  localparam logic [31:0] LINE_VEC [6] = '{
    32'h0A143207, 32'h64655A05, 32'h0000C80A,
    32'hFAF0FFFF, 32'h03040101, 32'h3C3D8003
  };

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          frame_start_i = 1'b0, line_start_i = 1'b0;
  logic          odd_vld_i = 1'b0, even_vld_i = 1'b0;
  logic [DW-1:0] odd_data_i = '0, even_data_i = '0;
  logic          pix_vld_o, pix_sol_o, pix_eol_o, pix_sof_o, pix_dark_line_o;
  logic [DW-1:0] pix_data_o;
  logic [1:0]    cnt_err_o;

  int checks = 0, errors = 0, ocnt = 0, line_base = 0;
  bit done = 1'b0;
  logic [DW-1:0] cap_data [64];
  logic [3:0]    cap_flag [64];

  always #4 clk_i = ~clk_i;

  dual_pix_interleaver #(
    .DW(DW), .DUMMY_N(DUMMY), .DARK_N(DARK), .ACT_N(ACT),
    .LINES_ACT(LA), .LINES_DARK(LD)
  ) dut_i (.*);

  always @(negedge clk_i) begin
    if (pix_vld_o) begin
      cap_data[ocnt % 64] = pix_data_o;
      cap_flag[ocnt % 64] = {pix_sol_o, pix_eol_o, pix_sof_o, pix_dark_line_o};
      ocnt++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int smp_val(input logic [31:0] v, input int ch, input int k);
    int db;
    db = (ch == 0) ? int'(v[31:24]) : int'(v[23:16]);
    if (k < DUMMY) return 'hEE;
    if (k < DUMMY + DARK) return (db + k - DUMMY) & 255;
    if (k < TOT) return (int'(v[15:8]) + int'(v[7:0]) * (2 * (k - DUMMY - DARK) + ch)) & 255;
    return 'h33;
  endfunction

  function automatic int exp_pix(input logic [31:0] v, input int col);
    int s, d;
    s = 0;
    for (int c = 0; c < 2; c++)
      for (int j = 0; j < DARK; j++) s += smp_val(v, c, DUMMY + j);
    d = ((int'(v[15:8]) + int'(v[7:0]) * col) & 255) - s / (2 * DARK);
    return (d < 0) ? 0 : d;
  endfunction

  task automatic run_line(input logic [31:0] v, input bit fs, input int n_odd,
                          input int n_even, output logic [1:0] err);
    int n;
    n = (n_odd > n_even) ? n_odd : n_even;
    @(negedge clk_i);
    line_base = ocnt;
    line_start_i = 1'b1; frame_start_i = fs;
    @(negedge clk_i);
    err = cnt_err_o;
    line_start_i = 1'b0; frame_start_i = 1'b0;
    for (int k = 0; k < n; k++) begin
      odd_vld_i = (k < n_odd); odd_data_i = DW'(smp_val(v, 0, k)); even_vld_i = 1'b0;
      @(negedge clk_i);
      odd_vld_i = 1'b0; even_vld_i = (k < n_even); even_data_i = DW'(smp_val(v, 1, k));
      @(negedge clk_i);
    end
    odd_vld_i = 1'b0; even_vld_i = 1'b0;
    repeat (4) @(negedge clk_i);
  endtask

  task automatic check_line(input logic [31:0] v, input int lidx, input int n_exp, input string tag);
    chk(ocnt - line_base == n_exp, {tag, " R1 R9 pixel count"}, ocnt - line_base, n_exp);
    for (int i = 0; i < n_exp; i++) begin
      int id;
      id = (line_base + i) % 64;
      chk(int'(cap_data[id]) == exp_pix(v, i), {tag, " R2 R3 R4 data"}, int'(cap_data[id]), exp_pix(v, i));
      chk(cap_flag[id][3] == (i == 0), {tag, " R5 sol"}, int'(cap_flag[id][3]), int'(i == 0));
      chk(cap_flag[id][2] == (i == COLS - 1), {tag, " R5 eol"}, int'(cap_flag[id][2]), int'(i == COLS - 1));
      chk(cap_flag[id][1] == (i == 0 && lidx == 0), {tag, " R6 sof"}, int'(cap_flag[id][1]), int'(i == 0 && lidx == 0));
      chk(cap_flag[id][0] == (lidx >= LA), {tag, " R7 dark line"}, int'(cap_flag[id][0]), int'(lidx >= LA));
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [1:0] err;
    repeat (3) @(negedge clk_i);
    chk(pix_vld_o == 1'b0, "R11 vld in reset", int'(pix_vld_o), 0);
    chk(cnt_err_o == 2'b00, "R11 err in reset", int'(cnt_err_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(pix_vld_o == 1'b0, "R11 vld after reset", int'(pix_vld_o), 0);

    for (int e = 0; e < 6; e++) begin
      run_line(LINE_VEC[e], (e % 3) == 0, TOT, TOT, err);
      chk(err == 2'b00, "R8 no false error", int'(err), 0);
      check_line(LINE_VEC[e], e % 3, COLS, "table");
    end

    // short odd line: partial output, error on next line, no leak (R10)
    run_line(LINE_VEC[0], 1'b1, TOT - 1, TOT, err);
    chk(err == 2'b00, "R8 before short line", int'(err), 0);
    check_line(LINE_VEC[0], 0, 4, "short R10");
    run_line(LINE_VEC[5], 1'b0, TOT, TOT, err);
    chk(err == 2'b01, "R8 odd short flagged", int'(err), 1);
    check_line(LINE_VEC[5], 1, COLS, "after short R10");
    @(negedge clk_i);
    chk(cnt_err_o == 2'b00, "R8 single cycle pulse", int'(cnt_err_o), 0);

    // long even line: excess sample dropped (R9), flagged next line
    run_line(LINE_VEC[1], 1'b0, TOT, TOT + 1, err);
    chk(err == 2'b00, "R8 before long line", int'(err), 0);
    check_line(LINE_VEC[1], 2, COLS, "long R9");
    run_line(LINE_VEC[4], 1'b1, TOT, TOT, err);
    chk(err == 2'b10, "R8 even long flagged", int'(err), 2);
    check_line(LINE_VEC[4], 0, COLS, "after long");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule